// File: doc/BRIEF.md
# Four-Way Tag Lookup Unit with Switchable Replacement

This unit holds the tag state of a small set-associative cache and answers a stream of byte-address read lookups. For each accepted request it decides whether the line is resident. It reports the way that hit, or the way chosen to receive the line on a miss. On a miss it writes the new tag into that way in the same step, because data storage and backing memory lie outside the block. When a valid line is displaced, its tag is reported on the response.

The victim policy is chosen per request by an input. With it high, the unit evicts the least recently touched way, where both hits and fills count as a touch. With it low, the unit evicts the way installed earliest, and hits do not change that order. Both kinds of bookkeeping are kept up to date all the time, so the policy input can change between requests. Two running counters hold the number of lookups and the number of misses. They are meant for measuring the hit rate of an address trace.

Top module: `assoc_lookup_unit`

## Requirements
- R1: A 12-bit byte address splits into tag = addr[11:5], set = addr[4] and offset = addr[3:0]. Addresses that differ only in the offset map to the same line.
- R2: During reset, and on the first response-free cycle after it, every way is invalid, both counters read 0 and rsp_valid is 0. req_ready is 1 from the cycle after reset is released.
- R3: A request is accepted when req_valid and req_ready are both 1 at a clock edge. Its response appears as a one-cycle rsp_valid pulse on the next cycle. No response appears without an accepted request.
- R4: A lookup whose tag is resident in its set returns rsp_hit=1, the way number holding that tag, and rsp_evict_valid=0.
- R5: On a miss in a set that still has invalid ways, the lowest-numbered invalid way is filled and rsp_evict_valid is 0.
- R6: With policy_lru=1, a miss in a full set replaces the way whose most recent hit or fill is the oldest.
- R7: With policy_lru=0, a miss in a full set replaces the way filled earliest. Hits do not change this order.
- R8: access_count rises by 1 for each accepted request, and miss_count rises by 1 for each miss. Both update on the same edge that raises rsp_valid.
- R9: A miss that displaces a valid line sets rsp_evict_valid=1 with the displaced tag on rsp_evict_tag. Afterwards the new tag hits and the displaced tag misses.
- R10: The two sets are independent. Fills and replacement order in one set do not affect the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| policy_lru | input | 1 | 1 selects least-recently-used victims, 0 selects first-in-first-out |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 12 | Byte address of the lookup |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_hit | output | 1 | 1 when the line was resident |
| rsp_way | output | 2 | Way that hit or was filled |
| rsp_evict_valid | output | 1 | A valid line was displaced by this miss |
| rsp_evict_tag | output | 7 | Tag of the displaced line |
| access_count | output | 16 | Number of accepted lookups since reset |
| miss_count | output | 16 | Number of misses since reset |

## Verification
A corrupted tag or valid bit shows up on the very next lookup to that set as a wrong hit flag or a wrong way. A stale LRU age or FIFO pointer stays hidden until the set is full. Only then does the wrong victim appear on rsp_way and rsp_evict_tag, and the later hit or miss of the displaced tag confirms it. For that reason the bench plays one mixed trace under each policy, where the two policies choose different victims in the same set, and it checks every response together with the final counts.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } repl_pol_e;
endpackage

// File: rtl/tag_store.sv
module tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 2,
  parameter int TAG_W = 7,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SET_W-1:0]       rd_set,
  input  logic [TAG_W-1:0]       rd_tag,
  output logic [WAYS-1:0]        match_vec,
  output logic [WAYS-1:0]        valid_vec,
  output logic [WAYS-1:0][TAG_W-1:0] tag_vec,
  input  logic                   wr_en,
  input  logic [SET_W-1:0]       wr_set,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic [TAG_W-1:0]       wr_tag
);
  logic [TAG_W-1:0] tag_mem [SETS*WAYS];
  logic [SETS-1:0][WAYS-1:0] vld_q;

  // tag array: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[{wr_set, wr_way}] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[wr_set][wr_way] <= 1'b1;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_vec[w]   = tag_mem[{rd_set, WAY_W'(w)}];
    assign valid_vec[w] = vld_q[rd_set][w];
    assign match_vec[w] = vld_q[rd_set][w] && (tag_vec[w] == rd_tag);
  end
endmodule

// File: rtl/repl_engine.sv
module repl_engine #(
  parameter int WAYS = 4,
  parameter int SETS = 2,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_lru,
  input  logic [SET_W-1:0] sel_set,
  input  logic [WAYS-1:0]  valid_vec,
  output logic [WAY_W-1:0] victim_way,
  input  logic             touch_en,
  input  logic             install,
  input  logic [WAY_W-1:0] touch_way
);
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [SETS-1:0][WAY_W-1:0]           fifo_q;

  logic             have_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest_way;

  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[sel_set][w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
    end
  end

  always_comb begin
    if (have_free)    victim_way = free_way;
    else if (use_lru) victim_way = oldest_way;
    else              victim_way = fifo_q[sel_set];
  end

  // ages form a permutation of 0..WAYS-1 within each set
  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_age
      always_ff @(posedge clk) begin
        if (rst) begin
          age_q[s][w] <= WAY_W'(w);
        end else if (touch_en && sel_set == SET_W'(s)) begin
          if (touch_way == WAY_W'(w))
            age_q[s][w] <= '0;
          else if (age_q[s][w] < age_q[s][touch_way])
            age_q[s][w] <= age_q[s][w] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) fifo_q[s] <= '0;
      else if (touch_en && install && sel_set == SET_W'(s))
        fifo_q[s] <= fifo_q[s] + 1'b1;
    end
  end
endmodule

// File: rtl/stat_counters.sv
module stat_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_inc,
  input  logic             miss_inc,
  output logic [CNT_W-1:0] acc_cnt,
  output logic [CNT_W-1:0] miss_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt  <= '0;
      miss_cnt <= '0;
    end else begin
      if (acc_inc)  acc_cnt  <= acc_cnt + 1'b1;
      if (miss_inc) miss_cnt <= miss_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/assoc_lookup_unit.sv
module assoc_lookup_unit #(
  parameter int ADDR_W = 12,
  parameter int LINE_B = 16,
  parameter int SETS   = 2,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 16,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 0,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              policy_lru,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_evict_valid,
  output logic [TAG_W-1:0]  rsp_evict_tag,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  miss_count
);
  import cache_pkg::*;

  logic             accept;
  logic [SET_W-1:0] a_set;
  logic [TAG_W-1:0] a_tag;
  logic [WAYS-1:0]  match_vec, valid_vec;
  logic [WAYS-1:0][TAG_W-1:0] tag_vec;
  logic             is_hit;
  logic [WAY_W-1:0] hit_way, victim_way, pick_way;
  repl_pol_e        pol;

  assign accept = req_valid && req_ready;
  assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign pol    = repl_pol_e'(policy_lru);

  if (SETS > 1) begin : g_idx
    assign a_set = req_addr[OFF_W +: SET_W];
  end else begin : g_noidx
    assign a_set = '0;
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign is_hit   = |match_vec;
  assign pick_way = is_hit ? hit_way : victim_way;

  tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .rd_set    (a_set),
    .rd_tag    (a_tag),
    .match_vec (match_vec),
    .valid_vec (valid_vec),
    .tag_vec   (tag_vec),
    .wr_en     (accept && !is_hit),
    .wr_set    (a_set),
    .wr_way    (victim_way),
    .wr_tag    (a_tag)
  );

  repl_engine #(.WAYS(WAYS), .SETS(SETS)) u_repl (
    .clk        (clk),
    .rst        (rst),
    .use_lru    (pol == POL_LRU),
    .sel_set    (a_set),
    .valid_vec  (valid_vec),
    .victim_way (victim_way),
    .touch_en   (accept),
    .install    (!is_hit),
    .touch_way  (pick_way)
  );

  stat_counters #(.CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst      (rst),
    .acc_inc  (accept),
    .miss_inc (accept && !is_hit),
    .acc_cnt  (access_count),
    .miss_cnt (miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready       <= 1'b0;
      rsp_valid       <= 1'b0;
      rsp_hit         <= 1'b0;
      rsp_way         <= '0;
      rsp_evict_valid <= 1'b0;
      rsp_evict_tag   <= '0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit         <= is_hit;
        rsp_way         <= pick_way;
        rsp_evict_valid <= !is_hit && valid_vec[victim_way];
        rsp_evict_tag   <= tag_vec[victim_way];
      end
    end
  end
endmodule

// File: rtl/assoc_lookup_chk.sv
module assoc_lookup_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_evict_valid,
  input logic [CNT_W-1:0] access_count,
  input logic [CNT_W-1:0] miss_count
);
  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && access_count == '0 && miss_count == '0));

  // R3
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R3
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R4
  hit_no_evict_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !rsp_evict_valid);

  // R8
  access_step_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> access_count == $past(access_count) + CNT_W'(1));

  // R8
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> miss_count == $past(miss_count) + CNT_W'(1));

  // R8
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && !rsp_hit) |-> $stable(miss_count));
endmodule

bind assoc_lookup_unit assoc_lookup_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .rsp_valid       (rsp_valid),
  .rsp_hit         (rsp_hit),
  .rsp_evict_valid (rsp_evict_valid),
  .access_count    (access_count),
  .miss_count      (miss_count)
);

// File: tb/assoc_lookup_unit_bench.sv
module assoc_lookup_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        policy_lru = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_evict_valid;
  logic [1:0]  rsp_way;
  logic [6:0]  rsp_evict_tag;
  logic [15:0] access_count, miss_count;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assoc_lookup_unit u_assoc_lookup_unit (
    .clk(clk), .rst(rst), .policy_lru(policy_lru),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_evict_valid(rsp_evict_valid), .rsp_evict_tag(rsp_evict_tag),
    .access_count(access_count), .miss_count(miss_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where the response is visible
  task automatic lookup(input logic [11:0] a, input bit ex_hit, input int ex_way,
                        input bit ex_ev, input int ex_tag, input string req);
    req_addr  = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " rsp_valid"}, int'(rsp_valid), 1);
    check({req, " hit"}, int'(rsp_hit), int'(ex_hit));
    check({req, " way"}, int'(rsp_way), ex_way);
    check({req, " evict_valid"}, int'(rsp_evict_valid), int'(ex_ev));
    if (ex_ev) check({req, " evict_tag"}, int'(rsp_evict_tag), ex_tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 counters zero in reset", int'(access_count) + int'(miss_count), 0);
    check("R2 rsp_valid low in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 ready after reset", int'(req_ready), 1);
  endtask

  task automatic test_idle();
    repeat (3) @(negedge clk);
    check("R3 no response while idle", int'(rsp_valid), 0);
    check("R8 access_count idle", int'(access_count), 0);
  endtask

  // trace; tag=addr[11:5], set=addr[4]
  task automatic test_lru_trace();
    policy_lru = 1'b1;
    lookup(12'h110, 0, 0, 0, 0, "R5 R10 set1 first fill");
    lookup(12'h136, 0, 1, 0, 0, "R5 set1 second fill");
    lookup(12'h202, 0, 0, 0, 0, "R10 set0 first fill independent");
    lookup(12'h1A3, 0, 1, 0, 0, "R5 set0 fill w1");
    lookup(12'h102, 0, 2, 0, 0, "R5 set0 fill w2");
    lookup(12'h361, 0, 3, 0, 0, "R5 set0 fill w3");
    lookup(12'h204, 1, 0, 0, 0, "R1 R4 offset change hits w0");
    lookup(12'h114, 1, 0, 0, 0, "R4 set1 hit w0");
    lookup(12'h1A4, 1, 1, 0, 0, "R1 R4 hit w1");
    lookup(12'h177, 0, 2, 0, 0, "R5 set1 fill w2");
    lookup(12'h301, 0, 2, 1, 8'h08, "R6 R9 lru evicts w2 tag 8");
    lookup(12'h206, 1, 0, 0, 0, "R6 recent line kept");
    lookup(12'h135, 1, 1, 0, 0, "R4 set1 hit w1");
    lookup(12'h102, 0, 3, 1, 8'h1B, "R9 displaced tag misses, lru w3");
    lookup(12'h30F, 1, 2, 0, 0, "R9 new tag hits");
    check("R8 access count lru", int'(access_count), 15);
    check("R8 miss count lru", int'(miss_count), 9);
  endtask

  task automatic test_fifo_trace();
    policy_lru = 1'b0;
    lookup(12'h110, 0, 0, 0, 0, "R5 set1 fill w0");
    lookup(12'h136, 0, 1, 0, 0, "R5 set1 fill w1");
    lookup(12'h202, 0, 0, 0, 0, "R5 set0 fill w0");
    lookup(12'h1A3, 0, 1, 0, 0, "R5 set0 fill w1");
    lookup(12'h102, 0, 2, 0, 0, "R5 set0 fill w2");
    lookup(12'h361, 0, 3, 0, 0, "R5 set0 fill w3");
    lookup(12'h204, 1, 0, 0, 0, "R4 hit w0");
    lookup(12'h114, 1, 0, 0, 0, "R4 set1 hit w0");
    lookup(12'h1A4, 1, 1, 0, 0, "R4 hit w1");
    lookup(12'h177, 0, 2, 0, 0, "R5 set1 fill w2");
    lookup(12'h301, 0, 0, 1, 8'h10, "R7 fifo evicts earliest w0 despite hit");
    lookup(12'h206, 0, 1, 1, 8'h0D, "R7 R9 next fifo w1");
    lookup(12'h135, 1, 1, 0, 0, "R10 set1 untouched");
    check("R8 access count fifo", int'(access_count), 13);
    check("R8 miss count fifo", int'(miss_count), 9);
  endtask

  initial begin
    do_reset();
    test_idle();
    test_lru_trace();
    do_reset();
    test_fifo_trace();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule